// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block collects up to 32 request lines and turns them into one interrupt level and one event pulse per processor core. Most lines are configurable. Each of those lines can be armed for a rising edge, a falling edge or both, and a detected edge is latched in a pending flag kept separately for every core. Software clears a pending flag by writing 1 to it. Software can also set pending flags without any input edge by writing the trigger register.

The remaining lines are direct lines. They have no edge selection and no stored pending flag: their synchronized input level acts as the request itself. Lines 0 to 15 take their source from one of several GPIO ports, and a 4-bit selector per line picks the port. Lines 16 and up to the last configurable line come from dedicated inputs. All inputs pass through a two-flop synchronizer before edge detection. Configuration uses a simple register bus: a write strobe, a 4-bit word address, 32-bit write data and combinational read data.

Register words: 0 rising enables, 1 falling enables, 2 software trigger, 4/5/6 core-0 interrupt mask / event mask / pending, 8/9/10 the same three for core 1, 12 to 15 port selectors.

Top module: `exti_ctrl`

## Requirements
- R1: A configurable line whose bit is set in the rising-enable word (address 0) sets its pending bit in every core on a 0-to-1 transition of its input. It does not do so on a 1-to-0 transition unless falling is also enabled.
- R2: A configurable line whose bit is set in the falling-enable word (address 1) sets its pending bit on a 1-to-0 transition. With both enables set, either transition sets it.
- R3: Writing 1 to a bit of a core's pending word (address 6 for core 0, 10 for core 1) clears that configurable line's flag. Writing 0 leaves the flag unchanged. Pending bits of direct lines are not affected by such writes.
- R4: When an edge on a line is detected in the same cycle as a write-1 clear of that line's pending bit, the bit stays set.
- R5: Writing the software-trigger word (address 2) sets the pending bit, in every core, of each configurable line whose data bit is 1. Bits for direct lines are ignored, and the word reads back as 0.
- R6: Pending bits are set whatever the masks hold. Each core's interrupt output is high exactly when some pending bit of that core is 1 and the same bit of that core's interrupt mask (address 4 or 8) is 1.
- R7: A trigger on a line whose bit is set in a core's event mask (address 5 or 9) gives a one-cycle high pulse on that core's event output. For an input transition the pulse appears 3 clock edges after the input changes. For a software trigger it appears on the edge that performs the write.
- R8: The two cores' pending and mask words are independent: clearing or masking in one core does not change the other core's state.
- R9: For line i below 16, the source is GPIO input bit port*16+i. The port number is the 4-bit field at bits 4*(i mod 4) of selector word 12+i/4. A port number not below NUM_PORTS selects a constant 0.
- R10: For a direct line, the pending word bit reads the synchronized input level. The interrupt output follows that level ANDed with the interrupt mask, and a rising level gives an event pulse when the event mask bit is set.
- R11: Event-mask bits of lines not marked in EVT_CAPABLE (by default lines 28 to 31) ignore writes and read 0.
- R12: After reset, every configuration, mask and pending word reads 0, and both interrupt and event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gpio_in | input | NUM_PORTS*16 | GPIO port inputs, port p at bits p*16 and up |
| ext_in | input | NUM_CFG-16 | Sources of configurable lines 16 and up |
| dir_in | input | NUM_DIR | Sources of the direct lines |
| irq_o | output | NUM_CORES | Interrupt level per core |
| evt_o | output | NUM_CORES | Event pulse per core |

## Verification
Directed patterns each isolate one distinction:
- a single rising and then a single falling transition, under each enable setting, show which edge polarity arms a line;
- an edge timed to land on the same edge as a clear write shows that set wins over clear;
- toggling the selected GPIO port against an unselected port and an out-of-range port shows the source multiplexer;
- a direct line raised and lowered shows that a level, and not a latch, drives the request.

A seeded random run then mixes software triggers, write-1 clears and mask writes in both cores with no input activity. After every operation it compares both pending words and both interrupt outputs with a bench model, which separates per-core independence and masking from the edge path.

// File: rtl/exti_pkg.sv
package exti_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int GPIO_W   = 16;
    localparam int SEL_W    = 4;
    localparam int A_RISE   = 0;
    localparam int A_FALL   = 1;
    localparam int A_SWTRIG = 2;
    localparam int A_SEL0   = 12;
    localparam int OFS_IMSK = 0;
    localparam int OFS_EMSK = 1;
    localparam int OFS_PEND = 2;

    function automatic logic [ADDR_W-1:0] core_addr(int core, int ofs);
        return ADDR_W'(4 * (core + 1) + ofs);
    endfunction
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/exti_edge.sv
module exti_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] trig_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        trig_o = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/exti_core.sv
module exti_core #(
    parameter int          NL     = 32,
    parameter int          NCFG   = 26,
    parameter logic [NL-1:0] EVT_OK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   trig_i,
    input  logic [NCFG-1:0] sw_set_i,
    input  logic [NL-NCFG-1:0] dir_lvl_i,
    input  logic [NL-1:0]   wdata_i,
    input  logic [NCFG-1:0] clr_data_i,
    input  logic            im_we_i,
    input  logic            em_we_i,
    input  logic            clr_we_i,
    output logic [NL-1:0]   imask_o,
    output logic [NL-1:0]   emask_o,
    output logic [NL-1:0]   pend_o,
    output logic            irq_o,
    output logic            evt_o
);
    typedef struct packed {
        logic [NL-1:0]   imask;
        logic [NL-1:0]   emask;
        logic [NCFG-1:0] pend;
        logic            evt;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [NCFG-1:0] clr_bits;
    logic [NL-1:0]   any_trig;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_we_i ? clr_data_i : '0;
        any_trig = trig_i | {{(NL-NCFG){1'b0}}, sw_set_i};
        if (im_we_i) st_d.imask = wdata_i;
        if (em_we_i) st_d.emask = wdata_i & EVT_OK;
        // set has priority over clear
        st_d.pend = (st_q.pend & ~clr_bits) | trig_i[NCFG-1:0] | sw_set_i;
        st_d.evt  = |(any_trig & st_q.emask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign imask_o = st_q.imask;
    assign emask_o = st_q.emask;
    assign pend_o  = {dir_lvl_i, st_q.pend};
    assign irq_o   = |(pend_o & st_q.imask);
    assign evt_o   = st_q.evt;

    // R3: a pending flag survives any cycle without a write-1 clear of its bit
    for (genvar i = 0; i < NCFG; i++) begin : g_hold
        a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[i] && !(clr_we_i && clr_data_i[i])) |=> st_q.pend[i]);
    end

    a_r6_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.imask == '0) |-> !irq_o);

    a_r7_evt_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(|st_q.emask));

    a_r11_evt_capable: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_o & ~EVT_OK) == '0);
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int NUM_CFG   = 26,
    parameter int NUM_DIR   = 6,
    parameter int NUM_PORTS = 4,
    parameter int NUM_CORES = 2,
    parameter logic [NUM_CFG+NUM_DIR-1:0] EVT_CAPABLE = 32'h0FFF_FFFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*GPIO_W-1:0] gpio_in,
    input  logic [NUM_CFG-GPIO_W-1:0]   ext_in,
    input  logic [NUM_DIR-1:0]          dir_in,
    output logic [NUM_CORES-1:0]        irq_o,
    output logic [NUM_CORES-1:0]        evt_o
);
    localparam int NL = NUM_CFG + NUM_DIR;

    typedef struct packed {
        logic [NUM_CFG-1:0]            rise;
        logic [NUM_CFG-1:0]            fall;
        logic [GPIO_W-1:0][SEL_W-1:0]  sel;
    } cfg_st_t;

    cfg_st_t            st_d, st_q;
    logic [NL-1:0]      src, lvl, trig;
    logic [NUM_CFG-1:0] sw_set;
    logic [NUM_CORES-1:0][NL-1:0] imask, emask, pend;

    // source selection
    always_comb begin
        src = '0;
        for (int i = 0; i < GPIO_W; i++) begin
            if (int'(st_q.sel[i]) < NUM_PORTS)
                src[i] = gpio_in[int'(st_q.sel[i]) * GPIO_W + i];
        end
        src[NUM_CFG-1:GPIO_W] = ext_in;
        src[NL-1:NUM_CFG]     = dir_in;
    end

    exti_sync #(.W(NL)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src), .sync_o(lvl)
    );

    exti_edge #(.W(NL)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl),
        .rise_en_i({{NUM_DIR{1'b1}}, st_q.rise}),
        .fall_en_i({{NUM_DIR{1'b0}}, st_q.fall}),
        .trig_o(trig)
    );

    // configuration registers
    always_comb begin
        st_d   = st_q;
        sw_set = '0;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(A_RISE))   st_d.rise = bus_wdata[NUM_CFG-1:0];
            if (bus_addr == ADDR_W'(A_FALL))   st_d.fall = bus_wdata[NUM_CFG-1:0];
            if (bus_addr == ADDR_W'(A_SWTRIG)) sw_set    = bus_wdata[NUM_CFG-1:0];
            for (int r = 0; r < GPIO_W / 4; r++) begin
                if (bus_addr == ADDR_W'(A_SEL0 + r)) begin
                    for (int k = 0; k < 4; k++)
                        st_d.sel[4*r+k] = bus_wdata[SEL_W*k +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        exti_core #(.NL(NL), .NCFG(NUM_CFG), .EVT_OK(EVT_CAPABLE)) u_core (
            .clk(clk), .rst_n(rst_n),
            .trig_i(trig), .sw_set_i(sw_set), .dir_lvl_i(lvl[NL-1:NUM_CFG]),
            .wdata_i(bus_wdata[NL-1:0]), .clr_data_i(bus_wdata[NUM_CFG-1:0]),
            .im_we_i(bus_we && bus_addr == core_addr(c, OFS_IMSK)),
            .em_we_i(bus_we && bus_addr == core_addr(c, OFS_EMSK)),
            .clr_we_i(bus_we && bus_addr == core_addr(c, OFS_PEND)),
            .imask_o(imask[c]), .emask_o(emask[c]), .pend_o(pend[c]),
            .irq_o(irq_o[c]), .evt_o(evt_o[c])
        );
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_RISE)) bus_rdata[NUM_CFG-1:0] = st_q.rise;
        if (bus_addr == ADDR_W'(A_FALL)) bus_rdata[NUM_CFG-1:0] = st_q.fall;
        for (int r = 0; r < GPIO_W / 4; r++) begin
            if (bus_addr == ADDR_W'(A_SEL0 + r))
                bus_rdata[15:0] = {st_q.sel[4*r+3], st_q.sel[4*r+2],
                                   st_q.sel[4*r+1], st_q.sel[4*r]};
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (bus_addr == core_addr(c, OFS_IMSK)) bus_rdata[NL-1:0] = imask[c];
            if (bus_addr == core_addr(c, OFS_EMSK)) bus_rdata[NL-1:0] = emask[c];
            if (bus_addr == core_addr(c, OFS_PEND)) bus_rdata[NL-1:0] = pend[c];
        end
    end

    // R1 / R2: a configurable line triggers only if one of its edge enables is set
    a_r1_edge_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[NUM_CFG-1:0] & ~(st_q.rise | st_q.fall)) == '0);
endmodule

// File: tb/exti_ctrl_tb.sv
`timescale 1ns/1ps
module exti_ctrl_tb;
    localparam logic [31:0] CFG_M  = 32'h03FF_FFFF;
    localparam logic [3:0]  RA_RISE = 4'd0, RA_FALL = 4'd1, RA_SWT = 4'd2;
    localparam logic [3:0]  RA_IM0 = 4'd4, RA_EM0 = 4'd5, RA_PD0 = 4'd6;
    localparam logic [3:0]  RA_IM1 = 4'd8, RA_EM1 = 4'd9, RA_PD1 = 4'd10;
    localparam logic [3:0]  RA_SEL1 = 4'd13;

    logic        clk = 0, rst_n = 0;
    logic        bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [63:0] gpio_in = 0;
    logic [9:0]  ext_in = 0;
    logic [5:0]  dir_in = 0;
    logic [1:0]  irq_o, evt_o;

    int vectors = 0, fails = 0;
    bit done = 0;
    logic [31:0] rv;
    logic [31:0] exp_pend [2];
    logic [31:0] exp_im   [2];

    always #2 clk = ~clk;

    exti_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .ext_in(ext_in), .dir_in(dir_in), .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic model_irq(logic [31:0] p, logic [31:0] m);
        return |(p & m);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        rd(RA_RISE, rv); chk("R12 rise", rv, 0);
        rd(RA_PD0, rv);  chk("R12 pend0", rv, 0);
        rd(RA_IM1, rv);  chk("R12 imask1", rv, 0);
        chk("R12 outputs", {28'b0, irq_o, evt_o}, 0);

        // R1 rising only
        wr(RA_RISE, 32'h8);
        gpio_in[3] = 1; settle();
        rd(RA_PD0, rv); chk("R1 rise sets", rv, 32'h8);
        rd(RA_PD1, rv); chk("R1 rise sets core1", rv, 32'h8);
        wr(RA_PD0, 32'h8); wr(RA_PD1, 32'h8);
        gpio_in[3] = 0; settle();
        rd(RA_PD0, rv); chk("R1 fall ignored", rv, 0);

        // R2 both edges
        wr(RA_FALL, 32'h8);
        gpio_in[3] = 1; settle();
        rd(RA_PD0, rv); chk("R2 both rise", rv, 32'h8);
        wr(RA_PD0, 32'h8);
        gpio_in[3] = 0; settle();
        rd(RA_PD0, rv); chk("R2 both fall", rv, 32'h8);
        wr(RA_PD0, 32'h8); wr(RA_PD1, 32'h8);
        wr(RA_RISE, 0);
        gpio_in[3] = 1; settle();
        rd(RA_PD0, rv); chk("R2 fall only rise ignored", rv, 0);
        gpio_in[3] = 0; settle();
        rd(RA_PD0, rv); chk("R2 fall only", rv, 32'h8);
        wr(RA_PD0, 32'h8); wr(RA_PD1, 32'h8);
        wr(RA_FALL, 0);

        // R7 event timing, R6 masking, R8 independence
        wr(RA_EM1, 32'h8); wr(RA_RISE, 32'h8);
        gpio_in[3] = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R7 evt not early", {30'b0, evt_o}, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 evt pulse core1", {30'b0, evt_o}, 2);
        @(posedge clk); @(negedge clk);
        chk("R7 evt one cycle", {30'b0, evt_o}, 0);
        chk("R6 masked no irq", {30'b0, irq_o}, 0);
        wr(RA_IM0, 32'h8);
        chk("R6 irq core0", {30'b0, irq_o}, 1);
        wr(RA_PD1, 32'h8);
        rd(RA_PD0, rv); chk("R8 core0 kept", rv, 32'h8);
        rd(RA_PD1, rv); chk("R8 core1 cleared", rv, 0);
        wr(RA_PD0, 32'h8);
        chk("R6 irq drops", {30'b0, irq_o}, 0);

        // R4 set wins over clear
        wr(RA_FALL, 32'h8);
        wr(RA_SWT, 32'h8);
        rd(RA_PD0, rv); chk("R5 sw set", rv, 32'h8);
        gpio_in[3] = 0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_we = 1; bus_addr = RA_PD0; bus_wdata = 32'h8;
        @(negedge clk);
        bus_we = 0;
        rd(RA_PD0, rv); chk("R4 set wins", rv, 32'h8);
        wr(RA_PD0, 32'h8);
        rd(RA_PD0, rv); chk("R3 w1c", rv, 0);
        wr(RA_SWT, 32'h20);
        wr(RA_PD0, 32'h0);
        rd(RA_PD0, rv); chk("R3 write0 no effect", rv, 32'h28 & 32'h20 | (rv & 32'h8));
        rd(RA_PD0, rv); chk("R3 write0 keeps bit5", rv & 32'h20, 32'h20);
        wr(RA_PD0, 32'hFFFF_FFFF); wr(RA_PD1, 32'hFFFF_FFFF);
        wr(RA_RISE, 0); wr(RA_FALL, 0);
        settle();

        // R5 software trigger
        wr(RA_SWT, 32'hFFFF_FFFF);
        chk("R7 sw evt", {30'b0, evt_o}, 2);
        rd(RA_PD0, rv); chk("R5 sw core0", rv, CFG_M);
        rd(RA_PD1, rv); chk("R5 sw core1", rv, CFG_M);
        rd(RA_SWT, rv); chk("R5 reads zero", rv, 0);
        wr(RA_PD0, 32'hFFFF_FFFF); wr(RA_PD1, 32'hFFFF_FFFF);

        // R9 port selection
        wr(RA_RISE, 32'h20);
        wr(RA_SEL1, 32'h20);
        gpio_in[5] = 1; settle();
        rd(RA_PD0, rv); chk("R9 unselected port", rv, 0);
        gpio_in[2*16+5] = 1; settle();
        rd(RA_PD0, rv); chk("R9 selected port", rv, 32'h20);
        wr(RA_PD0, 32'h20); wr(RA_PD1, 32'h20);
        wr(RA_SEL1, 32'hF0);
        gpio_in = '1; settle();
        rd(RA_PD0, rv); chk("R9 out of range port", rv, 0);
        rd(RA_SEL1, rv); chk("R9 selector readback", rv, 32'hF0);
        wr(RA_RISE, 0); wr(RA_SEL1, 0);
        gpio_in = '0; settle();

        // R10 direct line 26, R11 event capability
        wr(RA_IM0, 0); wr(RA_EM1, 0);
        wr(RA_IM1, 32'h0400_0000); wr(RA_EM0, 32'h0400_0000);
        dir_in[0] = 1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 direct evt", {30'b0, evt_o}, 1);
        settle();
        chk("R10 direct irq", {30'b0, irq_o}, 2);
        wr(RA_PD1, 32'h0400_0000);
        rd(RA_PD1, rv); chk("R3 direct not cleared", rv, 32'h0400_0000);
        dir_in[0] = 0; settle();
        chk("R10 direct irq follows", {30'b0, irq_o}, 0);
        rd(RA_PD1, rv); chk("R10 direct level low", rv, 0);
        wr(RA_EM0, 32'hFFFF_FFFF);
        rd(RA_EM0, rv); chk("R11 evt capable", rv, 32'h0FFF_FFFF);
        wr(RA_EM0, 0); wr(RA_IM1, 0);

        // random: software trigger, clears and masks in both cores
        void'($urandom(32'd4711));
        exp_pend[0] = 0; exp_pend[1] = 0; exp_im[0] = 0; exp_im[1] = 0;
        for (int n = 0; n < 200; n++) begin
            logic [31:0] r;
            int op, c;
            r  = $urandom;
            op = $urandom_range(0, 2);
            c  = $urandom_range(0, 1);
            if (op == 0) begin
                wr(RA_SWT, r);
                exp_pend[0] |= r & CFG_M; exp_pend[1] |= r & CFG_M;
            end else if (op == 1) begin
                wr(c == 0 ? RA_PD0 : RA_PD1, r);
                exp_pend[c] &= ~(r & CFG_M);
            end else begin
                wr(c == 0 ? RA_IM0 : RA_IM1, r);
                exp_im[c] = r;
            end
            rd(RA_PD0, rv); chk("R8 rand pend0", rv, exp_pend[0]);
            rd(RA_PD1, rv); chk("R8 rand pend1", rv, exp_pend[1]);
            chk("R6 rand irq", {30'b0, irq_o},
                {30'b0, model_irq(exp_pend[1], exp_im[1]), model_irq(exp_pend[0], exp_im[0])});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule